// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter with a selectable prescaler and a period compare. An instruction-rate enable drives the prescaler. The prescaler advances the counter. When the counter equals the period value on an increment cycle, the counter restarts from zero and the block sends out a one-cycle match pulse. That unscaled pulse can serve as a time base for a PWM unit or a serial shifter.

A 4-bit postscaler divides the match events and sets a sticky interrupt flag. The flag reaches the interrupt pin only when its enable bit is set. Software reaches the block through a simple register port: a write strobe with address and data, and a combinational read mux. Through this port it can load the count, the period and the control fields, and it can clear the flag.

A small mode state machine has three states: OFF, RUN and DOZE. It is clocked from the control register's run bit and the sleep input, and counting happens only in RUN. The transitions are:
- Any state goes to DOZE while sleep is high.
- With sleep low, any state goes to RUN when the run bit is set.
- With sleep low, any state goes to OFF when the run bit is clear.

Top module: `period_timer`

## Requirements
- R1: In RUN, the count rises by exactly one on each prescaler terminal tick. It does not change on any other cycle unless software writes it.
- R2: Control bits [5:4] select the prescale ratio: 00 divides the enable ticks by 1, 01 divides them by 4, and 10 or 11 divides them by 16.
- R3: On an increment cycle where the count equals the period, the count becomes 00h at that edge. In the same edge match_pulse goes high, and it stays high for that single cycle.
- R4: After reset the registers read as follows: count 00h, period FFh, control 00h, interrupt register 00h. Both match_pulse and irq are low.
- R5: Control bits [3:0] hold N. The flag is set on every (N+1)-th match event counted since the postscaler was last cleared.
- R6: Address 3 holds the flag in bit 0 and the enable in bit 1. The irq output is high exactly when both bits are 1.
- R7: A write to the count (address 0) or to the control register (address 2) clears the prescaler and postscaler counters and suppresses that cycle's increment. A control write leaves the count unchanged.
- R8: While the machine is in DOZE, the count does not advance and the period and count keep their values, apart from software writes.
- R9: When control bit 6 (run) is clear, the machine settles in OFF. Neither the prescaler nor the count advances.
- R10: The flag stays set until software writes bit 0 of address 3 as 0. A postscaler set event in the same cycle as such a write wins, so the flag ends up set.
- R11: Mode changes are registered. A change of sleep or of the run bit first affects counting on the cycle after the edge that samples it.
- R12: The period register is written at address 1. It changes only on such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Instruction-rate clock enable feeding the prescaler |
| sleep | input | 1 | Holds the timer in DOZE while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 count, 1 period, 2 control, 3 interrupt |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as wr_addr |
| rd_data | output | 8 | Combinational read data |
| match_pulse | output | 1 | One-cycle pulse per period match |
| irq | output | 1 | Flag AND enable |

## Verification
The assertions assume a few things about the inputs:
- The register address selects exactly one register per write.
- The read address and write strobe are stable between clock edges.
- Software writes are the only way the count or period changes other than by counting.

The bench drives every input at the falling edge from a seeded $urandom stream, so each value is settled well before the sampling edge. It keeps register writes sparse enough that the prescaler and postscaler can reach their terminal counts, and it places directed writes of the count, control and flag in the same cycles as wrap and set events.

// File: rtl/pt_pkg.sv
package pt_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_RUN  = 2'd1,
        MODE_DOZE = 2'd2
    } pt_mode_e;

    localparam logic [1:0] ADDR_COUNT  = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;
    localparam logic [1:0] ADDR_IRQ    = 2'd3;
endpackage

// File: rtl/pt_mode_fsm.sv
module pt_mode_fsm
    import pt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_bit,
    input  logic     sleep,
    output pt_mode_e mode_q,
    output logic     running
);
    pt_mode_e mode_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_d;
    end

    // next-state: sleep dominates, then the run bit
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_OFF:  if (sleep) mode_d = MODE_DOZE;
                       else if (run_bit) mode_d = MODE_RUN;
            MODE_RUN:  if (sleep) mode_d = MODE_DOZE;
                       else if (!run_bit) mode_d = MODE_OFF;
            MODE_DOZE: if (!sleep) mode_d = run_bit ? MODE_RUN : MODE_OFF;
            default:   mode_d = MODE_OFF;
        endcase
    end

    always_comb begin
        running = (mode_q == MODE_RUN);
    end
endmodule

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [1:0]       sel,
    output logic             tick_out,
    output logic [PRE_W-1:0] cnt_q
);
    localparam logic [PRE_W-1:0] TERM_MAX = {PRE_W{1'b1}};
    localparam logic [PRE_W-1:0] TERM_MID = PRE_W'(3);

    logic [PRE_W-1:0] term;

    always_comb begin
        unique case (sel)
            2'b00:   term = '0;
            2'b01:   term = TERM_MID;
            default: term = TERM_MAX;
        endcase
        tick_out = advance && (cnt_q == term);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear)   cnt_q <= '0;
        else if (advance) cnt_q <= tick_out ? '0 : cnt_q + PRE_W'(1);
    end
endmodule

// File: rtl/pt_postscaler.sv
module pt_postscaler #(
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              event_in,
    input  logic [POST_W-1:0] ratio,
    output logic              done,
    output logic [POST_W-1:0] cnt_q
);
    always_comb begin
        done = event_in && !clear && (cnt_q == ratio);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clear)    cnt_q <= '0;
        else if (event_in) cnt_q <= done ? '0 : cnt_q + POST_W'(1);
    end
endmodule

// File: rtl/period_timer.sv
module period_timer
    import pt_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 4,
    parameter int POST_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             sleep,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             match_pulse,
    output logic             irq
);
    localparam int PRE_LO = POST_W;
    localparam int RUN_B  = POST_W + 2;
    localparam int CTRL_W = POST_W + 3;

    logic [CNT_W-1:0]  count_q, period_q;
    logic [POST_W-1:0] ctl_post;
    logic [1:0]        ctl_pre;
    logic              ctl_run;
    logic              flag_q, en_q;
    logic [PRE_W-1:0]  pre_cnt;
    logic [POST_W-1:0] post_cnt;
    pt_mode_e          mode_q;
    logic              running, pre_tick, post_done;
    logic              cnt_wr, per_wr, ctl_wr, irq_wr, scl_clr;
    logic              step, at_period, wrap;

    always_comb begin
        cnt_wr    = wr_en && (wr_addr == ADDR_COUNT);
        per_wr    = wr_en && (wr_addr == ADDR_PERIOD);
        ctl_wr    = wr_en && (wr_addr == ADDR_CTRL);
        irq_wr    = wr_en && (wr_addr == ADDR_IRQ);
        scl_clr   = cnt_wr || ctl_wr;
        step      = pre_tick && !scl_clr;
        at_period = (count_q == period_q);
        wrap      = step && at_period;
    end

    pt_mode_fsm u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_bit (ctl_run),
        .sleep   (sleep),
        .mode_q  (mode_q),
        .running (running)
    );

    pt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (scl_clr),
        .advance  (running && tick_en),
        .sel      (ctl_pre),
        .tick_out (pre_tick),
        .cnt_q    (pre_cnt)
    );

    pt_postscaler #(.POST_W(POST_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (scl_clr),
        .event_in (wrap),
        .ratio    (ctl_post),
        .done     (post_done),
        .cnt_q    (post_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q     <= '0;
            match_pulse <= 1'b0;
        end else begin
            match_pulse <= wrap;
            if (cnt_wr)    count_q <= wr_data;
            else if (step) count_q <= at_period ? '0 : count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '1;
            ctl_post <= '0;
            ctl_pre  <= '0;
            ctl_run  <= 1'b0;
            flag_q   <= 1'b0;
            en_q     <= 1'b0;
        end else begin
            if (per_wr) period_q <= wr_data;
            if (ctl_wr) begin
                ctl_post <= wr_data[POST_W-1:0];
                ctl_pre  <= wr_data[PRE_LO+1:PRE_LO];
                ctl_run  <= wr_data[RUN_B];
            end
            if (irq_wr) en_q <= wr_data[1];
            // set event wins over a software clear
            if (post_done)   flag_q <= 1'b1;
            else if (irq_wr) flag_q <= wr_data[0];
        end
    end

    always_comb begin
        irq = flag_q && en_q;
        unique case (rd_addr)
            ADDR_COUNT:  rd_data = count_q;
            ADDR_PERIOD: rd_data = period_q;
            ADDR_CTRL:   rd_data = CNT_W'({ctl_run, ctl_pre, ctl_post});
            default:     rd_data = CNT_W'({en_q, flag_q});
        endcase
    end

    logic [CTRL_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/pt_checker.sv
module pt_checker
    import pt_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 4,
    parameter int POST_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  period_q,
    input logic              flag_q,
    input logic              match_pulse,
    input logic              irq,
    input pt_mode_e          mode_q,
    input logic [PRE_W-1:0]  pre_cnt,
    input logic [POST_W-1:0] post_cnt
);
    logic cw, pw, iw, sw;
    always_comb begin
        cw = wr_en && (wr_addr == ADDR_COUNT);
        pw = wr_en && (wr_addr == ADDR_PERIOD);
        iw = wr_en && (wr_addr == ADDR_IRQ);
        sw = wr_en && (wr_addr == ADDR_COUNT || wr_addr == ADDR_CTRL);
    end

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cw |=> (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1) || count_q == '0));

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (count_q == '0));

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

    p_scaler_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw |=> (pre_cnt == '0 && post_cnt == '0));

    p_doze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_RUN && !cw) |=> $stable(count_q));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !iw) |=> flag_q);

    p_period_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !pw |=> $stable(period_q));
endmodule

bind period_timer pt_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W), .POST_W(POST_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .count_q     (count_q),
    .period_q    (period_q),
    .flag_q      (flag_q),
    .match_pulse (match_pulse),
    .irq         (irq),
    .mode_q      (mode_q),
    .pre_cnt     (pre_cnt),
    .post_cnt    (post_cnt)
);

// File: tb/period_timer_test.sv
module period_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, sleep = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       match_pulse, irq;

    int total = 0, bad = 0;
    string ph = "R4 reset";

    period_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sleep(sleep),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .match_pulse(match_pulse), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model built from the requirements
    logic [7:0] m_cnt, m_per;
    logic [6:0] m_ctl;
    logic       m_flag, m_en, m_pulse;
    int         m_mode, m_pre, m_post;

    function automatic int term_of(input logic [1:0] s);
        return (s == 2'b00) ? 0 : (s == 2'b01) ? 3 : 15;   // R2
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_per;
            2'd2: return {1'b0, m_ctl};
            default: return {6'd0, m_en, m_flag};
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 8'hFF; m_ctl = 0; m_flag = 0; m_en = 0;
            m_pulse = 0; m_mode = 0; m_pre = 0; m_post = 0;
        end else begin
            bit adv, tk, clr, stp, wrp, setf;
            int nmode;
            adv   = (m_mode == 1) && tick_en;                    // R9 R8
            tk    = adv && (m_pre == term_of(m_ctl[5:4]));
            clr   = wr_en && (wr_addr == 2'd0 || wr_addr == 2'd2); // R7
            nmode = sleep ? 2 : (m_ctl[6] ? 1 : 0);               // R11
            stp   = tk && !clr;
            wrp   = stp && (m_cnt == m_per);                      // R3
            setf  = 0;
            if (clr) begin m_pre = 0; m_post = 0; end
            else begin
                if (adv) m_pre = tk ? 0 : m_pre + 1;
                if (wrp) begin
                    if (m_post == int'(m_ctl[3:0])) begin m_post = 0; setf = 1; end // R5
                    else m_post = m_post + 1;
                end
            end
            if (wr_en && wr_addr == 2'd0) m_cnt = wr_data;
            else if (stp) m_cnt = wrp ? 8'd0 : m_cnt + 8'd1;      // R1
            if (wr_en && wr_addr == 2'd1) m_per = wr_data;        // R12
            if (wr_en && wr_addr == 2'd2) m_ctl = wr_data[6:0];
            if (wr_en && wr_addr == 2'd3) m_en = wr_data[1];
            if (setf) m_flag = 1;                                 // R10
            else if (wr_en && wr_addr == 2'd3) m_flag = wr_data[0];
            m_pulse = wrp;
            m_mode  = nmode;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle(input bit w, input logic [1:0] a, input logic [7:0] d,
                         input bit t, input bit s);
        @(negedge clk);
        chk({ph, " R3 match_pulse"}, {7'd0, match_pulse}, {7'd0, m_pulse});
        chk({ph, " R6 irq"}, {7'd0, irq}, {7'd0, m_flag && m_en});
        chk($sformatf("%s R1 rd[%0d]", ph, rd_addr), rd_data, exp_read(rd_addr));
        wr_en = w; wr_addr = a; wr_data = d; tick_en = t; sleep = s;
        rd_addr = 2'($urandom_range(0, 3));
    endtask

    task automatic idle(input int n, input bit t, input bit s);
        for (int i = 0; i < n; i++) cycle(1'b0, 2'd0, 8'd0, t, s);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        #(CLK_PERIOD * 3);
        // R4: reset values
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #1;
            chk($sformatf("R4 reset rd[%0d]", a), rd_data, (a == 1) ? 8'hFF : 8'h00);
        end
        chk("R4 reset match_pulse", {7'd0, match_pulse}, 8'd0);
        chk("R4 reset irq", {7'd0, irq}, 8'd0);
        @(negedge clk); rst_n = 1'b1;

        ph = "R1 R3 divide-by-1 period 5";
        cycle(1, 2'd1, 8'd5, 0, 0);
        cycle(1, 2'd3, 8'h02, 0, 0);
        cycle(1, 2'd2, 8'h40, 0, 0);
        idle(40, 1, 0);

        ph = "R2 R5 divide-by-4 post 3";
        cycle(1, 2'd2, 8'h52, 0, 0);
        for (int i = 0; i < 200; i++) cycle(0, 2'd0, 8'd0, 1'($urandom_range(0, 1)), 0);

        ph = "R2 divide-by-16 code 11";
        cycle(1, 2'd2, 8'h70, 0, 0);
        idle(300, 1, 0);

        ph = "R8 R11 sleep hold";
        idle(30, 1, 1);
        cycle(1, 2'd1, 8'd9, 1, 1);
        idle(10, 1, 1);
        idle(40, 1, 0);

        ph = "R9 run bit clear";
        cycle(1, 2'd2, 8'h00, 1, 0);
        idle(40, 1, 0);

        ph = "R7 count and control writes";
        cycle(1, 2'd2, 8'h41, 1, 0);
        cycle(1, 2'd1, 8'd3, 1, 0);
        for (int i = 0; i < 60; i++) begin
            if (i % 7 == 6) cycle(1, 2'd0, 8'd1, 1, 0);
            else if (i % 11 == 10) cycle(1, 2'd2, 8'h41, 1, 0);
            else cycle(0, 2'd0, 8'd0, 1, 0);
        end

        ph = "R10 flag clear and set race";
        cycle(1, 2'd2, 8'h40, 1, 0);
        cycle(1, 2'd1, 8'd0, 1, 0);
        for (int i = 0; i < 40; i++) cycle(1, 2'd3, 8'h02, 1, 0);
        cycle(1, 2'd2, 8'h00, 1, 0);
        idle(3, 1, 0);
        cycle(1, 2'd3, 8'h02, 1, 0);
        idle(5, 1, 0);

        ph = "R5 R11 R12 random mix";
        for (int i = 0; i < 15000; i++) begin
            bit w; logic [1:0] a; logic [7:0] d;
            w = ($urandom_range(0, 19) == 0);
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            if (a == 2'd2) d[6] = ($urandom_range(0, 7) != 0);
            if (a == 2'd1) d = 8'($urandom_range(0, 12));
            cycle(w, a, d, ($urandom_range(0, 3) != 0), ($urandom_range(0, 30) == 0));
        end
        idle(2, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule